// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Bank

This block is the software-visible configuration bank of a DRAM controller. It is a 32-bit register file on a simple word-addressed bus (address, write strobe, write data, read strobe, read data). Every register except the protection word refuses writes until the unlock key has been written to the protection word. Writing any other value there locks the bank again.

Some registers do more than store data. The configuration word keeps a set of fields wired to constants: a hardware revision, a cache-ready flag, a reserved span, an aperture code and a DRAM size code. Two status and control words always report an idle PHY and a finished, passing ECC self-test, whatever software writes to them. Two parameters choose the silicon generation and the DRAM capacity. Together they decide the constant fields.

The bench and the notes use the default build: generation 3 with 1024 MB of DRAM. In that build the configuration word resets to 0x3000000E.

Top module: `smc_cfg_bank`

## Requirements
- R1: After reset the protection word reads 0, so the bank is locked. The configuration word reads its fixed value. Every other in-range word reads 0.
- R2: A write of 0xFC600309 to byte address 0x000 makes the protection word read 1. A write of any other value there makes it read 0. The protection word accepts writes whether the bank is locked or unlocked.
- R3: While the protection word holds 0, writes to every other address leave the stored contents unchanged.
- R4: The word index is the byte address shifted right by 2, and address bits 1:0 are ignored. Read data appears on the clock edge after the edge that samples the read strobe. A read and a write to the same word in the same cycle return the value held before the write.
- R5: A word index of NUM_WORDS (default 256) or more is out of range. A read there returns 0, and a write there changes no register; in particular it does not alias onto a lower index.
- R6: In the configuration word at byte 0x004, the bits in mask 0xF00FC04F ignore written data and keep their fixed values. All other bits store what is written.
- R7: The fixed configuration value is the revision in bits 31:28, plus 0xC in bits 3:2, plus the size code in bits 1:0, plus bit 19 set for generation 2 only. The revision is 1 for generation 2 and 3 for generation 3. The size code is 0..3 for 128/256/512/1024 MB on generation 2 and for 256/512/1024/2048 MB on generation 3. Any other generation or size stops elaboration.
- R8: A write to the PHY status word at byte 0x060 stores the data with bit 0 (busy) cleared. On generation 3 it also sets bit 4 (PLL locked).
- R9: A write to the ECC test word at byte 0x070 stores the data with bit 12 (done) set and bit 13 (fail) cleared.
- R10: All other in-range words store the written 32-bit value unchanged while the bank is unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | BUS_AW (12) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions watch the stored state on every cycle. The read-only configuration bits must always match their fixed value. The busy and fail bits must never be set. A locked cycle must leave the configuration word untouched. An out-of-range read must return zero. A correct key write must open the bank and a wrong one must close it. Only the bench's scenarios can show the byte-to-index mapping with misaligned low bits, the absence of aliasing above the window, the read-before-write ordering, and the exact values that come back after mixed random traffic across lock and unlock phases.

// File: rtl/smc_cfg_pkg.sv
`timescale 1ns/1ps
package smc_cfg_pkg;

   localparam logic [31:0] UNLOCK_KEY  = 32'hFC60_0309;

   // word indices whose behaviour differs from plain storage
   localparam int unsigned IDX_PROT    = 0;
   localparam int unsigned IDX_CFG     = 1;
   localparam int unsigned IDX_PHYSTAT = 24;
   localparam int unsigned IDX_ECCTST  = 28;

   // configuration bits that never take written data
   localparam logic [31:0] CFG_RO_MASK = 32'hF00F_C04F;

   localparam logic [31:0] PHY_BUSY_BIT = 32'h0000_0001;
   localparam logic [31:0] PLL_LOCK_BIT = 32'h0000_0010;
   localparam logic [31:0] ECC_DONE_BIT = 32'h0000_1000;
   localparam logic [31:0] ECC_FAIL_BIT = 32'h0000_2000;

   // Size code for a generation and capacity; 4 marks an unsupported pair.
   function automatic int unsigned size_code(input int unsigned gen,
                                             input int unsigned mb);
      int unsigned base;
      base = (gen == 2) ? 128 : 256;
      for (int unsigned k = 0; k < 4; k++) begin
         if (mb == (base << k)) return k;
      end
      return 4;
   endfunction

   function automatic logic [31:0] cfg_fixed(input int unsigned gen,
                                             input int unsigned code);
      logic [31:0] f;
      f = 32'h0000_000C | (32'(code) & 32'h3);
      if (gen == 2) f = f | 32'h1008_0000;
      else          f = f | 32'h3000_0000;
      return f;
   endfunction

endpackage

// File: rtl/smc_key_gate.sv
`timescale 1ns/1ps
module smc_key_gate
   import smc_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prot_wr_i,
   input  logic [31:0] wdata_i,
   output logic        unlocked_o
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          open_q <= 1'b0;
      else if (prot_wr_i)  open_q <= (wdata_i == UNLOCK_KEY);
   end

   assign unlocked_o = open_q;

   p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_i && wdata_i == UNLOCK_KEY) |=> unlocked_o);

   p_bad_key_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr_i && wdata_i != UNLOCK_KEY) |=> !unlocked_o);

   p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_wr_i |=> $stable(unlocked_o));

endmodule

// File: rtl/smc_write_shaper.sv
`timescale 1ns/1ps
module smc_write_shaper
   import smc_cfg_pkg::*;
#(
   parameter int unsigned GEN   = 3,
   parameter int unsigned IDX_W = 8,
   parameter logic [31:0] FIXED = 32'h3000_000E
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      data_o
);

   logic [31:0] pll_force;

   generate
      if (GEN == 3) begin : g_pll_forced
         assign pll_force = PLL_LOCK_BIT;
      end else begin : g_pll_free
         assign pll_force = '0;
      end
   endgenerate

   always_comb begin
      data_o = wdata_i;
      if (idx_i == IDX_W'(IDX_CFG)) begin
         data_o = (wdata_i & ~CFG_RO_MASK) | FIXED;
      end else if (idx_i == IDX_W'(IDX_PHYSTAT)) begin
         data_o = (wdata_i & ~PHY_BUSY_BIT) | pll_force;
      end else if (idx_i == IDX_W'(IDX_ECCTST)) begin
         data_o = (wdata_i | ECC_DONE_BIT) & ~ECC_FAIL_BIT;
      end
   end

endmodule

// File: rtl/smc_word_store.sv
`timescale 1ns/1ps
module smc_word_store
   import smc_cfg_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 256,
   parameter int unsigned IDX_W     = 8,
   parameter logic [31:0] FIXED     = 32'h3000_000E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] widx_i,
   input  logic [31:0]      wdata_i,
   input  logic             re_i,
   input  logic             rin_range_i,
   input  logic [IDX_W-1:0] ridx_i,
   input  logic             lock_open_i,
   output logic [31:0]      rdata_o
);

   logic [31:0] mem [NUM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++) begin
            mem[i] <= (i == IDX_CFG) ? FIXED : 32'h0;
         end
      end else if (we_i) begin
         mem[widx_i] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (re_i) begin
         if (!rin_range_i)                     rdata_o <= '0;
         else if (ridx_i == IDX_W'(IDX_PROT))  rdata_o <= {31'b0, lock_open_i};
         else                                  rdata_o <= mem[ridx_i];
      end
   end

   p_cfg_ro_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem[IDX_CFG] & CFG_RO_MASK) == (FIXED & CFG_RO_MASK));

   p_phy_never_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem[IDX_PHYSTAT][0] == 1'b0);

   p_ecc_never_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem[IDX_ECCTST][13] == 1'b0);

   p_locked_cfg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_open_i |=> $stable(mem[IDX_CFG]));

endmodule

// File: rtl/smc_cfg_bank.sv
`timescale 1ns/1ps
module smc_cfg_bank
   import smc_cfg_pkg::*;
#(
   parameter int unsigned GEN       = 3,
   parameter int unsigned DRAM_MB   = 1024,
   parameter int unsigned NUM_WORDS = 256,
   parameter int unsigned BUS_AW    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata
);

   localparam int unsigned WIDX_W = BUS_AW - 2;
   localparam int unsigned IDX_W  = $clog2(NUM_WORDS);
   localparam int unsigned CODE   = size_code(GEN, DRAM_MB);
   localparam logic [31:0] FIXED  = cfg_fixed(GEN, CODE);

   generate
      if (GEN != 2 && GEN != 3) begin : g_bad_gen
         $error("smc_cfg_bank: generation must be 2 or 3");
      end
      if (CODE > 3) begin : g_bad_size
         $error("smc_cfg_bank: DRAM capacity not supported by this generation");
      end
      if (NUM_WORDS <= IDX_ECCTST || (1 << IDX_W) != NUM_WORDS) begin : g_bad_depth
         $error("smc_cfg_bank: word count must be a power of two above the ECC word");
      end
      if ((1 << WIDX_W) < NUM_WORDS) begin : g_bad_aw
         $error("smc_cfg_bank: address too narrow for the word count");
      end
   endgenerate

   logic [WIDX_W-1:0] word_idx;
   logic [IDX_W-1:0]  short_idx;
   logic              in_range;
   logic              hit_prot;
   logic              unlocked;
   logic              store_we;
   logic [31:0]       shaped;
   logic [1:0]        unused_byte_lane;

   assign unused_byte_lane = bus_addr[1:0];
   assign word_idx  = bus_addr[BUS_AW-1:2];
   assign short_idx = word_idx[IDX_W-1:0];
   assign in_range  = (word_idx < WIDX_W'(NUM_WORDS));
   assign hit_prot  = (word_idx == WIDX_W'(IDX_PROT));
   assign store_we  = bus_wr && in_range && !hit_prot && unlocked;

   smc_key_gate u_key (
      .clk        (clk),
      .rst_n      (rst_n),
      .prot_wr_i  (bus_wr && hit_prot),
      .wdata_i    (bus_wdata),
      .unlocked_o (unlocked)
   );

   smc_write_shaper #(
      .GEN   (GEN),
      .IDX_W (IDX_W),
      .FIXED (FIXED)
   ) u_shape (
      .idx_i   (short_idx),
      .wdata_i (bus_wdata),
      .data_o  (shaped)
   );

   smc_word_store #(
      .NUM_WORDS (NUM_WORDS),
      .IDX_W     (IDX_W),
      .FIXED     (FIXED)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (store_we),
      .widx_i      (short_idx),
      .wdata_i     (shaped),
      .re_i        (bus_rd),
      .rin_range_i (in_range),
      .ridx_i      (short_idx),
      .lock_open_i (unlocked),
      .rdata_o     (bus_rdata)
   );

   p_oob_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_range) |=> bus_rdata == 32'h0);

   p_prot_read_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_prot && !bus_wr) |=> bus_rdata == {31'b0, unlocked});

   p_idle_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_smc_cfg_bank.sv
`timescale 1ns/1ps
module sim_smc_cfg_bank;

   localparam int unsigned GEN  = 3;
   localparam int unsigned MB   = 1024;
   localparam int unsigned NW   = 256;
   localparam int unsigned AW   = 12;
   localparam logic [31:0] KEY  = 32'hFC60_0309;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;

   always #2.5 clk = ~clk;

   smc_cfg_bank #(.GEN(GEN), .DRAM_MB(MB), .NUM_WORDS(NW), .BUS_AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   logic [31:0] model [NW];
   logic        m_open;

   function automatic logic [31:0] exp_fixed();
      int unsigned base, code;
      base = (GEN == 2) ? 128 : 256;
      code = 0;
      while ((base << code) != MB) code++;
      return ((GEN == 2) ? 32'h1008_0000 : 32'h3000_0000) | 32'hC | code;
   endfunction

   function automatic logic [31:0] exp_shape(int unsigned idx, logic [31:0] d);
      case (idx)
         1:  return (d & ~32'hF00F_C04F) | exp_fixed();
         24: return (d & ~32'h1) | ((GEN == 3) ? 32'h10 : 32'h0);
         28: return (d | 32'h1000) & ~32'h2000;
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(int unsigned idx);
      if (idx >= NW) return 32'h0;
      if (idx == 0)  return {31'b0, m_open};
      return model[idx];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NW; i++) model[i] = 32'h0;
      model[1] = exp_fixed();
      m_open = 1'b0;
   endtask

   task automatic model_write(int unsigned idx, logic [31:0] d);
      if (idx >= NW) return;
      if (idx == 0) m_open = (d == KEY);
      else if (m_open) model[idx] = exp_shape(idx, d);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(int'(a >> 2), d);
   endtask

   task automatic rd_chk(logic [AW-1:0] a, string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, bus_rdata, exp_read(int'(a >> 2)));
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk(12'h000, "R1 prot");
      rd_chk(12'h004, "R1 cfg");
      check("R7 fixed value", exp_read(1), 32'h3000_000E);
      rd_chk(12'h060, "R1 phy");
      rd_chk(12'h070, "R1 ecc");
      rd_chk(12'h0A0, "R1 plain");

      // R3 locked writes dropped
      wr(12'h004, 32'h0000_0F00);
      wr(12'h0A0, 32'hDEAD_BEEF);
      rd_chk(12'h004, "R3 cfg locked");
      rd_chk(12'h0A0, "R3 plain locked");

      // R2 unlock
      wr(12'h000, KEY);
      rd_chk(12'h000, "R2 unlocked");

      // R6 config merge
      wr(12'h004, 32'hFFFF_FFFF);
      rd_chk(12'h004, "R6 cfg ones");
      check("R6 expect", exp_read(1), 32'h3FF0_3FBE);
      wr(12'h004, 32'h0);
      rd_chk(12'h004, "R6 cfg zeros");

      // R8 phy status
      wr(12'h060, 32'hFFFF_FFFF);
      rd_chk(12'h060, "R8 phy ones");
      wr(12'h060, 32'h0);
      rd_chk(12'h060, "R8 phy zeros");
      check("R8 expect", exp_read(24), 32'h0000_0010);

      // R9 ecc test
      wr(12'h070, 32'hFFFF_FFFF);
      rd_chk(12'h070, "R9 ecc ones");
      wr(12'h070, 32'h0);
      rd_chk(12'h070, "R9 ecc zeros");

      // R10 plain + R4 misaligned
      wr(12'h040, 32'hA5A5_5A5A);
      rd_chk(12'h040, "R10 plain");
      rd_chk(12'h043, "R4 low bits ignored");

      // R5 out of range, no alias onto index 1 / 16
      wr(12'h404, 32'h1234_5678);
      wr(12'h440, 32'h0BAD_F00D);
      rd_chk(12'h004, "R5 no alias cfg");
      rd_chk(12'h040, "R5 no alias plain");
      rd_chk(12'h404, "R5 oob read zero");
      rd_chk(12'hFFC, "R5 top oob zero");

      // R4 same-cycle read and write
      @(negedge clk);
      bus_addr = 12'h040; bus_wdata = 32'h7777_1111; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R4 read before write", bus_rdata, 32'hA5A5_5A5A);
      model_write(16, 32'h7777_1111);
      rd_chk(12'h040, "R4 new value");

      // R2 wrong key relocks, R3 writes dropped again
      wr(12'h000, KEY ^ 32'h1);
      rd_chk(12'h000, "R2 relocked");
      wr(12'h040, 32'h0);
      rd_chk(12'h040, "R3 dropped after relock");

      // mixed random traffic
      for (int n = 0; n < 4000; n++) begin
         int unsigned sel, idx;
         logic [AW-1:0] a;
         logic [31:0] d;
         sel = $urandom_range(0, 9);
         case ($urandom_range(0, 5))
            0: idx = 0;
            1: idx = 1;
            2: idx = 24;
            3: idx = 28;
            4: idx = $urandom_range(NW, (1 << (AW - 2)) - 1);
            default: idx = $urandom_range(2, NW - 1);
         endcase
         a = AW'((idx << 2) | $urandom_range(0, 3));
         d = $urandom();
         if (sel < 2)       wr(12'h000, KEY);
         else if (sel < 5)  wr(a, d);
         else               rd_chk(a, (idx == 0) ? "R2 random" : (idx == 1) ? "R6 random" :
                                      (idx == 24) ? "R8 random" : (idx == 28) ? "R9 random" :
                                      (idx >= NW) ? "R5 random" : "R10 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule